// File: doc/BRIEF.md
# PLL Mode, Ratio and Lock-Status Register Block

This block holds the clock-management settings for one digital PLL and two analog PLLs: an enable register with one mode field per PLL, a ratio register with the digital PLL multiplier and divider, and a core-source register that picks what drives the core clock. It does not generate clocks. It works out when each PLL may claim lock and builds a read-only idle-status word from the lock flags and the core source.

Software reaches the registers through a word-addressed port. A write takes effect at the clock edge where `bus_sel` and `bus_we` are both high. Reads are combinational: `bus_rdata` follows `bus_addr` in the same cycle. The word offsets are 0 for the enable register, 1 for status, 2 for the ratio register and 3 for the core-source register.

Digital PLL lock is modelled by a small state machine. It counts internal reference periods, each of which is (divider+1) pulses of `ref_tick`. The states are:
- `LK_IDLE`: not in lock mode, or the multiplier is degenerate.
- `LK_COUNT`: counting toward lock.
- `LK_LOCKED`: locked.

The transitions are:
- `LK_IDLE` to `LK_COUNT` (start), when lock mode becomes requested.
- `LK_COUNT` to `LK_LOCKED` (settle), on the last internal reference period.
- `LK_COUNT` to `LK_COUNT` (restart), when the ratio changes.
- `LK_LOCKED` to `LK_COUNT` (relock), when the ratio changes.
- `LK_COUNT` or `LK_LOCKED` to `LK_IDLE` (drop), when lock mode is no longer requested.

The state machine acts on the register values that are being written in the same cycle, so it moves at the same edge as the write.

Top module: `pll_ctl_regs`

## Requirements
- R1: After reset the enable register reads 0x00000001 (digital PLL in low-power bypass), the ratio register reads 0, the core-source register reads 2, all lock flags are low, and the status word reads 0x00000071.
- R2: A write to the enable register (offset 0) keeps only the bits under 0x000000CF. The digital PLL mode is bits [1:0]: 1 is low-power bypass, 2 is fast-relock bypass and 3 is lock.
- R3: `rsvd_warn` is high for one cycle after a write that sets a reserved bit. The reserved bits are 0xFFFFFF30 for offset 0, 0xFC4000D7 for offset 2, and bits [31:2] for offset 3.
- R4: Analog PLL A (enable bits [7:6]) and analog PLL B (enable bits [3:2]) each report lock exactly when their field equals 3. These flags appear at status bits 9 and 8.
- R5: `cfg_error` is high while either analog field is 1 or 2, while the digital PLL mode is 0, or while the core source is 3.
- R6: A multiplier of 0 or 1 forces the digital PLL into bypass: `ratio_ok` is low and it never locks.
- R7: With mode 3 and a multiplier of at least 2, `dpll_locked` rises exactly 20×(divider+1) `ref_tick` pulses after entering lock mode. Without `ref_tick` pulses it stays low.
- R8: Leaving mode 3 clears `dpll_locked` at the same edge. A write that changes the multiplier or divider clears it and restarts the count.
- R9: A write to the ratio register (offset 2) stores the data masked with 0x03BFFF28. The multiplier is bits [21:12] and the divider is bits [11:8].
- R10: The core-source register (offset 3) keeps bits [1:0] (0 selects 32 kHz, 1 the PLL, 2 the doubled PLL, 3 illegal) and drives `core_src`.
- R11: The status word (offset 1) is 0x70, with analog lock at bits 9 and 8. Bits [1:0] read 3 when the core source is 0, otherwise 1 while the digital PLL is unlocked and 2 once it is locked.
- R12: Reads of offsets 4 and above return 0. Writes to the status offset or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One pulse per reference-clock period |
| bus_sel | input | 1 | Access select |
| bus_we | input | 1 | Write enable |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| dpll_locked | output | 1 | Digital PLL lock |
| apll_a_locked | output | 1 | Analog PLL A lock |
| apll_b_locked | output | 1 | Analog PLL B lock |
| core_src | output | 2 | Selected core clock source |
| ratio_ok | output | 1 | Multiplier is at least 2 |
| cfg_error | output | 1 | Illegal mode or source present |
| rsvd_warn | output | 1 | Reserved bits were written |

## Verification
The assertions check the following on every cycle:
- Register contents follow each write's mask.
- A reserved write raises the warning.
- Lock is only held while lock mode with a valid ratio is requested.
- The period counter stays in range.
- Lock only rises out of counting.

The bench scenarios are needed for the things a single-cycle property cannot see:
- The exact lock latency for different dividers.
- The restart after a ratio change.
- A stalled reference holding lock off.
- The status-word encodings and the unmapped-offset behaviour.

// File: rtl/pll_regs_pkg.sv
package pll_regs_pkg;
    localparam int DATA_W = 32;

    localparam int OFF_EN   = 0;
    localparam int OFF_STAT = 1;
    localparam int OFF_SEL1 = 2;
    localparam int OFF_SEL2 = 3;

    localparam logic [DATA_W-1:0] EN_KEEP    = 32'h0000_00CF;
    localparam logic [DATA_W-1:0] EN_RSVD    = 32'hFFFF_FF30;
    localparam logic [DATA_W-1:0] SEL1_KEEP  = 32'h03BF_FF28;
    localparam logic [DATA_W-1:0] SEL1_RSVD  = 32'hFC40_00D7;
    localparam logic [DATA_W-1:0] SEL2_KEEP  = 32'h0000_0003;
    localparam logic [DATA_W-1:0] STAT_BASE  = 32'h0000_0070;

    localparam logic [DATA_W-1:0] EN_RESET   = 32'h0000_0001;
    localparam logic [DATA_W-1:0] SEL2_RESET = 32'h0000_0002;

    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_COUNT  = 2'd1,
        LK_LOCKED = 2'd2
    } lock_state_t;

    typedef enum logic [1:0] {
        SRC_32K  = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_PLL2 = 2'd2,
        SRC_BAD  = 2'd3
    } core_src_t;
endpackage

// File: rtl/pll_reg_file.sv
module pll_reg_file
    import pll_regs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] sel1_q,
    output logic [DATA_W-1:0] sel2_q,
    output logic [DATA_W-1:0] en_nxt,
    output logic [DATA_W-1:0] sel1_nxt,
    output logic              warn_q
);
    logic wr;
    logic hit_en, hit_sel1, hit_sel2;
    logic warn_nxt;

    assign wr       = bus_sel && bus_we;
    assign hit_en   = wr && (bus_addr == ADDR_W'(OFF_EN));
    assign hit_sel1 = wr && (bus_addr == ADDR_W'(OFF_SEL1));
    assign hit_sel2 = wr && (bus_addr == ADDR_W'(OFF_SEL2));

    always_comb begin
        en_nxt   = en_q;
        sel1_nxt = sel1_q;
        warn_nxt = 1'b0;
        if (hit_en) begin
            en_nxt   = bus_wdata & EN_KEEP;
            warn_nxt = |(bus_wdata & EN_RSVD);
        end
        if (hit_sel1) begin
            sel1_nxt = bus_wdata & SEL1_KEEP;
            warn_nxt = |(bus_wdata & SEL1_RSVD);
        end
        if (hit_sel2) begin
            warn_nxt = |(bus_wdata & ~SEL2_KEEP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= EN_RESET;
            sel1_q <= '0;
            sel2_q <= SEL2_RESET;
            warn_q <= 1'b0;
        end else begin
            en_q   <= en_nxt;
            sel1_q <= sel1_nxt;
            warn_q <= warn_nxt;
            if (hit_sel2) sel2_q <= bus_wdata & SEL2_KEEP;
        end
    end

    // R2: enable register holds the masked write data
    assert_en_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_en |=> en_q == ($past(bus_wdata) & EN_KEEP));

    // R10: core-source register follows the low two bits written
    assert_sel2_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_sel2 |=> sel2_q[1:0] == $past(bus_wdata[1:0]));

    // R3: reserved enable bits raise the warning
    assert_en_warn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && |(bus_wdata & EN_RSVD)) |=> warn_q);
endmodule

// File: rtl/pll_ref_divider.sv
module pll_ref_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             ref_tick,
    input  logic [DIV_W-1:0] div,
    output logic             fint
);
    logic [DIV_W-1:0] pre_q;

    assign fint = run && ref_tick && (pre_q == div);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_q <= '0;
        end else if (run && ref_tick) begin
            pre_q <= (pre_q == div) ? '0 : pre_q + 1'b1;
        end
    end

    // R7: prescaler never passes the divider value while running
    assert_pre_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |-> pre_q <= div);
endmodule

// File: rtl/pll_lock_fsm.sv
module pll_lock_fsm
    import pll_regs_pkg::*;
#(
    parameter int LOCK_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_req_cur,
    input  logic lock_req_nxt,
    input  logic restart,
    input  logic fint,
    output logic run,
    output logic clr,
    output logic locked
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    lock_state_t state_q, state_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic last;

    assign last = fint && (cnt_q == CNT_W'(LOCK_CYCLES - 1));

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            LK_IDLE:   if (lock_req_nxt) state_nxt = LK_COUNT;
            LK_COUNT:  begin
                if (!lock_req_nxt)  state_nxt = LK_IDLE;
                else if (restart)   state_nxt = LK_COUNT;
                else if (last)      state_nxt = LK_LOCKED;
            end
            LK_LOCKED: begin
                if (!lock_req_nxt)  state_nxt = LK_IDLE;
                else if (restart)   state_nxt = LK_COUNT;
            end
            default:               state_nxt = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_nxt;
    end

    always_comb begin
        run    = (state_q == LK_COUNT);
        locked = (state_q == LK_LOCKED);
        clr    = (state_nxt == LK_COUNT) && (state_q != LK_COUNT || restart);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run && fint && state_nxt == LK_COUNT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: lock is only held while lock mode is in force
    assert_lock_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_LOCKED) |-> lock_req_cur);

    // R7: period counter stays below the lock count
    assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(LOCK_CYCLES));

    // R7: lock only rises out of the counting state
    assert_lock_from_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(state_q) == LK_COUNT);
endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
    import pll_regs_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int MULT_W      = 10,
    parameter int DIV_W       = 4,
    parameter int MULT_LSB    = 12,
    parameter int DIV_LSB     = 8,
    parameter int LOCK_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              dpll_locked,
    output logic              apll_a_locked,
    output logic              apll_b_locked,
    output logic [1:0]        core_src,
    output logic              ratio_ok,
    output logic              cfg_error,
    output logic              rsvd_warn
);
    localparam int RATIO_W   = MULT_W + DIV_W;
    localparam int RATIO_LSB = DIV_LSB;

    logic [DATA_W-1:0] en_q, sel1_q, sel2_q, en_nxt, sel1_nxt, status;
    logic [MULT_W-1:0] mult_q, mult_nxt;
    logic [DIV_W-1:0]  div_q;
    logic              lock_req_cur, lock_req_nxt, restart;
    logic              fint, run, clr;
    logic [1:0]        fld_a, fld_b;
    logic [1:0]        core_code;

    pll_reg_file #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .en_q(en_q), .sel1_q(sel1_q), .sel2_q(sel2_q),
        .en_nxt(en_nxt), .sel1_nxt(sel1_nxt), .warn_q(rsvd_warn)
    );

    assign mult_q   = sel1_q[MULT_LSB +: MULT_W];
    assign mult_nxt = sel1_nxt[MULT_LSB +: MULT_W];
    assign div_q    = sel1_q[DIV_LSB +: DIV_W];

    assign lock_req_cur = (en_q[1:0] == 2'd3) && (mult_q > MULT_W'(1));
    assign lock_req_nxt = (en_nxt[1:0] == 2'd3) && (mult_nxt > MULT_W'(1));
    assign restart      = sel1_nxt[RATIO_LSB +: RATIO_W] != sel1_q[RATIO_LSB +: RATIO_W];

    pll_ref_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run),
        .ref_tick(ref_tick), .div(div_q), .fint(fint)
    );

    pll_lock_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .lock_req_cur(lock_req_cur),
        .lock_req_nxt(lock_req_nxt), .restart(restart), .fint(fint),
        .run(run), .clr(clr), .locked(dpll_locked)
    );

    always_comb begin
        fld_a         = en_q[7:6];
        fld_b         = en_q[3:2];
        apll_a_locked = (fld_a == 2'd3);
        apll_b_locked = (fld_b == 2'd3);
        core_src      = sel2_q[1:0];
        ratio_ok      = mult_q > MULT_W'(1);
        cfg_error     = (fld_a == 2'd1) || (fld_a == 2'd2) ||
                        (fld_b == 2'd1) || (fld_b == 2'd2) ||
                        (en_q[1:0] == 2'd0) || (core_src == SRC_BAD);
        if (core_src == SRC_32K)  core_code = 2'd3;
        else if (!dpll_locked)    core_code = 2'd1;
        else                      core_code = 2'd2;
        status = STAT_BASE;
        status[9]   = apll_a_locked;
        status[8]   = apll_b_locked;
        status[1:0] = core_code;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFF_EN):   bus_rdata = en_q;
            ADDR_W'(OFF_STAT): bus_rdata = status;
            ADDR_W'(OFF_SEL1): bus_rdata = sel1_q;
            ADDR_W'(OFF_SEL2): bus_rdata = sel2_q;
            default:           bus_rdata = '0;
        endcase
    end

    // R6: a degenerate multiplier never shows lock
    assert_degenerate_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_ok |-> !dpll_locked);

    // R8: dropping out of lock mode clears lock at the next edge
    assert_drop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == ADDR_W'(OFF_EN) && bus_wdata[1:0] != 2'd3)
        |=> !dpll_locked);
endmodule

// File: tb/pll_ctl_regs_test.sv
module pll_ctl_regs_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ref_tick = 0;
    logic        bus_sel = 0, bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        dpll_locked, apll_a_locked, apll_b_locked, ratio_ok, cfg_error, rsvd_warn;
    logic [1:0]  core_src;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    pll_ctl_regs uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dpll_locked(dpll_locked),
        .apll_a_locked(apll_a_locked), .apll_b_locked(apll_b_locked),
        .core_src(core_src), .ratio_ok(ratio_ok), .cfg_error(cfg_error),
        .rsvd_warn(rsvd_warn)
    );

    localparam int NV = 10;
    localparam logic [3:0]  V_ADDR [NV] = '{0, 0, 2, 2, 3, 3, 3, 5, 1, 0};
    localparam logic [31:0] V_DATA [NV] = '{32'hFFFFFFFF, 32'h1, 32'hFFFFFFFF, 32'h0,
                                            32'h7, 32'h0, 32'h2, 32'h1234, 32'hFFFFFFFF, 32'h1};
    localparam logic [31:0] V_READ [NV] = '{32'hCF, 32'h1, 32'h03BFFF28, 32'h0,
                                            32'h3, 32'h0, 32'h2, 32'h0, 32'h71, 32'h1};
    localparam logic        V_WARN [NV] = '{1, 0, 1, 0, 1, 0, 0, 0, 0, 0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic count_lock(output int n);
        n = 0;
        while (!dpll_locked && n < 2000) begin
            @(posedge clk); @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(0, d); chk("R1 en", d, 32'h1);
        rd(2, d); chk("R1 sel1", d, 32'h0);
        rd(3, d); chk("R1 sel2", d, 32'h2);
        rd(1, d); chk("R1 status", d, 32'h71);
        chk("R1 locks", {29'd0, dpll_locked, apll_a_locked, apll_b_locked}, 32'h0);

        // R2 R3 R9 R10 R12 table walk
        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], V_DATA[i]);
            chk($sformatf("R3 warn row %0d", i), {31'd0, rsvd_warn}, {31'd0, V_WARN[i]});
            rd(V_ADDR[i] == 4'd5 ? 4'd5 : V_ADDR[i], d);
            chk($sformatf("R2/R9/R10/R12 read row %0d", i), d, V_READ[i]);
        end
        rd(0, d); chk("R12 status write ignored en", d, 32'h1);
        chk("R10 core_src", {30'd0, core_src}, 32'h2);

        // R4 analog locks
        wr(0, 32'hC1);
        chk("R4 a lock", {30'd0, apll_a_locked, apll_b_locked}, 32'h2);
        rd(1, d); chk("R4 status a", d, 32'h271);
        wr(0, 32'h0D);
        rd(1, d); chk("R4 status b", d, 32'h171);

        // R5 config error
        chk("R5 clean", {31'd0, cfg_error}, 32'h0);
        wr(0, 32'h41); chk("R5 analog field 1", {31'd0, cfg_error}, 32'h1);
        wr(0, 32'h09); chk("R5 analog field 2", {31'd0, cfg_error}, 32'h1);
        wr(0, 32'h00); chk("R5 dpll mode 0", {31'd0, cfg_error}, 32'h1);
        wr(0, 32'h01); wr(3, 32'h3); chk("R5 core src 3", {31'd0, cfg_error}, 32'h1);
        wr(3, 32'h2);

        // R6 degenerate multiplier
        ref_tick = 1;
        wr(2, 32'h0000_1000); wr(0, 32'h3);
        repeat (100) @(negedge clk);
        chk("R6 no lock", {30'd0, dpll_locked, ratio_ok}, 32'h0);

        // R7 stalled reference, then lock after 20 periods (div 0)
        ref_tick = 0;
        wr(2, 32'h0000_5000);
        repeat (50) @(negedge clk);
        chk("R7 stalled ref", {31'd0, dpll_locked}, 32'h0);
        chk("R6 ratio ok", {31'd0, ratio_ok}, 32'h1);
        wr(0, 32'h2); wr(0, 32'h3);
        ref_tick = 1;
        count_lock(n);
        chk("R7 latency div0", n, 20);
        rd(1, d); chk("R11 locked status", d, 32'h72);

        // R8 ratio change restarts, R7 div 2
        wr(2, 32'h0000_5200);
        chk("R8 ratio change clears", {31'd0, dpll_locked}, 32'h0);
        count_lock(n);
        chk("R7 latency div2", n, 60);

        // R8 leave lock mode
        wr(0, 32'h2);
        chk("R8 bypass clears", {31'd0, dpll_locked}, 32'h0);
        rd(1, d); chk("R11 unlocked status", d, 32'h71);
        wr(3, 32'h0);
        rd(1, d); chk("R11 32k source", d, 32'h73);
        rd(7, d); chk("R12 unmapped read", d, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule